// File: doc/BRIEF.md
# Conversion Sequencer with Ready and Error Flags

This block decides when a sigma-delta converter produces results and owns the flags that a serial front end reports to software. It counts timebase ticks to mark conversion periods and discards the first period after any start, because the digital filter is still settling then. It loads a 24-bit data register from a stand-in modulator/filter model at the end of each later period. It drives an active-low ready flag and an error flag, and it tells the modulator when to be powered.

Three operating modes come from a 2-bit mode field. In continuous mode a result lands once per period after the initial settling. In single mode one result is produced and the modulator then powers down while the result is held. In power-down mode nothing runs. The period length comes from a 3-bit rate code and a 2-bit clock-divider code. A configuration write or a change of the channel selection restarts settling. A strobe from the serial side marks that the data register has been read.

FSM states: `ST_SETTLE` (first, discarded period), `ST_CONV` (delivering results), `ST_HOLD` (single result held, modulator off), `ST_OFF` (power-down). The transitions are:

- SETTLE→CONV at period end.
- CONV→CONV at period end in continuous mode.
- CONV→HOLD at period end in single mode.
- RESTART from any state, on a configuration write or a channel change. It goes to SETTLE when the mode is continuous or single, and to OFF otherwise.

HOLD and OFF stay put until a RESTART.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, `rdy_n` is 1, `err_flag` is 0, `data_out` is 0, `active` is 1, and the block is settling as if in continuous mode.
- R2: The period P is B shifted left by `cdiv`, in ticks. B depends on the rate code as follows: 000→10, 001→12, 010→36, 011→60, 100→72, 101→72, 110→90, 111→126. The `cdiv` codes 00/01/10/11 therefore divide by 1/2/4/8.
- R3: After reset or a restart, the first result is taken on the 2P-th tick. In that cycle `mod_data` is loaded into `data_out`, `rdy_n` drops to 0 and `new_word` pulses for one cycle. `data_out` never changes at any other time.
- R4: In continuous mode (`mode`=00), each further result arrives every P ticks.
- R5: In continuous delivery, `rdy_n` goes to 1 on the (P−WARN)-th tick of each period, with WARN defaulting to 2. This happens whether or not the word was read.
- R6: A `rd_done` pulse sets `rdy_n` to 1 in the next cycle, unless a new result lands in the same cycle. It leaves `data_out` unchanged.
- R7: A `cfg_wr` pulse restarts the settling sequence and sets `rdy_n` to 1. A tick in the same cycle is not counted.
- R8: A change of the `chan` input restarts settling in the same way as R7.
- R9: In single mode (`mode`=10), one result arrives after 2P ticks. `active` then falls, and the result and `rdy_n`=0 remain however many ticks follow, until a read or a restart.
- R10: With `mode` 11 (power-down) or 01 (reserved, treated as power-down), a `cfg_wr` makes `active` 0 and `rdy_n` 1, and no result is produced.
- R11: `err_flag` is loaded from `mod_clamp` with each result. A `cfg_wr` with mode 00 or 10 clears it. A `cfg_wr` with mode 01 or 11 leaves it unchanged.
- R12: When `cread` is 1 as a result lands, `reload_sr` pulses together with `new_word`. Otherwise `reload_sr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase tick enable |
| cfg_wr | input | 1 | Configuration register write strobe |
| mode | input | 2 | Operating mode field |
| rate | input | 3 | Update-rate code |
| cdiv | input | 2 | Clock divider code |
| chan | input | 2 | Channel selection |
| rd_done | input | 1 | Data register read completed |
| cread | input | 1 | Continuous-read mode active |
| mod_data | input | DW | Result from modulator/filter model |
| mod_clamp | input | 1 | Result was clamped (out of range) |
| data_out | output | DW | Data register |
| rdy_n | output | 1 | Ready flag, low when an unread result is present |
| err_flag | output | 1 | Error flag for the last result |
| active | output | 1 | Modulator powered |
| new_word | output | 1 | One-cycle pulse when a result is loaded |
| reload_sr | output | 1 | Reload request for the output shift register |

## Verification
Results are timed with dense ticks (one every cycle) and with sparse ticks that have random idle gaps. This separates counting ticks from counting clocks. Random rate and divider codes check the period table and the shift by the divider, and each run is sampled one tick before and at the expected delivery. Directed sequences cover the remaining behaviour:

- restarts in mid-period from writes and from channel changes;
- single-shot hold across many ticks;
- power-down and reserved modes;
- error retention across a power-down write;
- the early warning edge one tick either side of its expected position.

// File: rtl/convseq_pkg.sv
package convseq_pkg;

    typedef enum logic [1:0] {
        MD_CONT   = 2'b00,
        MD_RSVD   = 2'b01,
        MD_SINGLE = 2'b10,
        MD_OFF    = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        ST_SETTLE,
        ST_CONV,
        ST_HOLD,
        ST_OFF
    } seq_state_e;

    // Base period in ticks for each rate code (undivided clock)
    function automatic int unsigned base_ticks(input logic [2:0] code);
        int unsigned t;
        unique case (code)
            3'd0: t = 10;
            3'd1: t = 12;
            3'd2: t = 36;
            3'd3: t = 60;
            3'd4: t = 72;
            3'd5: t = 72;
            3'd6: t = 90;
            3'd7: t = 126;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/convseq_period.sv
module convseq_period
    import convseq_pkg::*;
#(
    parameter int SCALE = 1,
    parameter int CNT_W = 10
) (
    input  logic [2:0]       rate,
    input  logic [1:0]       cdiv,
    output logic [CNT_W-1:0] period
);

    int unsigned scaled;

    always_comb begin
        scaled = base_ticks(rate) * SCALE;
        period = CNT_W'(scaled << cdiv);
    end

endmodule

// File: rtl/convseq_timer.sv
module convseq_timer #(
    parameter int CNT_W = 10,
    parameter int WARN  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic             pend,
    output logic             warn
);

    localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN);

    logic [CNT_W-1:0] cnt;
    logic             last;
    logic             step;

    assign step = run && !clear && tick;
    assign last = (cnt == period - 1'b1);
    assign pend = step && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    generate
        if (WARN > 0) begin : g_warn
            assign warn = step && (cnt == period - WARN_V - 1'b1);
        end else begin : g_nowarn
            assign warn = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import convseq_pkg::*;
#(
    parameter int DW    = 24,
    parameter int SCALE = 1,
    parameter int WARN  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cfg_wr,
    input  logic [1:0]    mode,
    input  logic [2:0]    rate,
    input  logic [1:0]    cdiv,
    input  logic [1:0]    chan,
    input  logic          rd_done,
    input  logic          cread,
    input  logic [DW-1:0] mod_data,
    input  logic          mod_clamp,
    output logic [DW-1:0] data_out,
    output logic          rdy_n,
    output logic          err_flag,
    output logic          active,
    output logic          new_word,
    output logic          reload_sr
);

    localparam int MAXP  = 126 * SCALE * 8;
    localparam int CNT_W = $clog2(MAXP + 1);

    seq_state_e       state, nxt;
    logic [1:0]       chan_q;
    logic             restart;
    logic             starts_conv;
    logic             run;
    logic             pend;
    logic             warn;
    logic             deliver;
    logic [CNT_W-1:0] period;

    assign restart     = cfg_wr || (chan != chan_q);
    assign starts_conv = (mode == MD_CONT) || (mode == MD_SINGLE);
    assign run         = (state == ST_SETTLE) || (state == ST_CONV);
    assign deliver     = (state == ST_CONV) && pend;
    assign active      = run;

    convseq_period #(.SCALE(SCALE), .CNT_W(CNT_W)) u_period (
        .rate   (rate),
        .cdiv   (cdiv),
        .period (period)
    );

    convseq_timer #(.CNT_W(CNT_W), .WARN(WARN)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart),
        .run    (run),
        .tick   (tick),
        .period (period),
        .pend   (pend),
        .warn   (warn)
    );

    // Channel watcher
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SETTLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_SETTLE: if (pend) nxt = ST_CONV;
            ST_CONV:   if (pend && mode == MD_SINGLE) nxt = ST_HOLD;
            ST_HOLD:   nxt = ST_HOLD;
            ST_OFF:    nxt = ST_OFF;
        endcase
        if (restart) nxt = starts_conv ? ST_SETTLE : ST_OFF;
    end

    // Output and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out  <= '0;
            rdy_n     <= 1'b1;
            err_flag  <= 1'b0;
            new_word  <= 1'b0;
            reload_sr <= 1'b0;
        end else begin
            new_word  <= deliver;
            reload_sr <= deliver && cread;
            if (restart) begin
                rdy_n <= 1'b1;
                if (cfg_wr && starts_conv) err_flag <= 1'b0;
            end else if (deliver) begin
                data_out <= mod_data;
                err_flag <= mod_clamp;
                rdy_n    <= 1'b0;
            end else if (rd_done || (state == ST_CONV && warn)) begin
                rdy_n <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic [1:0]    mode,
    input logic          rd_done,
    input logic [DW-1:0] data_out,
    input logic          rdy_n,
    input logic          err_flag,
    input logic          active,
    input logic          new_word,
    input logic          reload_sr
);

    // R3
    result_lowers_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_word |-> !rdy_n);

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !new_word |-> $stable(data_out));

    // R6
    read_raises_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (rdy_n || new_word));

    // R7
    cfg_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (rdy_n && !new_word));

    // R10
    pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && mode[0]) |=> !active);

    // R11
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_flag) |-> ($past(cfg_wr) || new_word));

    // R12
    reload_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_sr |-> new_word);

endmodule

bind conv_sequencer conv_sequencer_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .mode      (mode),
    .rd_done   (rd_done),
    .data_out  (data_out),
    .rdy_n     (rdy_n),
    .err_flag  (err_flag),
    .active    (active),
    .new_word  (new_word),
    .reload_sr (reload_sr)
);

// File: tb/test_conv_sequencer.sv
module test_conv_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 24;
    localparam int WARN = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [2:0]    rate = 3'b100;
    logic [1:0]    cdiv = 2'b00;
    logic [1:0]    chan = 2'b00;
    logic          rd_done = 1'b0;
    logic          cread = 1'b0;
    logic [DW-1:0] mod_data = '0;
    logic          mod_clamp = 1'b0;
    logic [DW-1:0] data_out;
    logic          rdy_n, err_flag, active, new_word, reload_sr;

    int n_vec = 0;
    int n_bad = 0;
    int n_words = 0;
    bit finished = 1'b0;
    bit sparse = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_sequencer #(.DW(DW), .WARN(WARN)) i_conv_sequencer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wr(cfg_wr), .mode(mode),
        .rate(rate), .cdiv(cdiv), .chan(chan), .rd_done(rd_done), .cread(cread),
        .mod_data(mod_data), .mod_clamp(mod_clamp), .data_out(data_out),
        .rdy_n(rdy_n), .err_flag(err_flag), .active(active),
        .new_word(new_word), .reload_sr(reload_sr)
    );

    always @(negedge clk) if (rst_n && new_word) n_words++;

    function automatic int exp_period(input logic [2:0] r, input logic [1:0] d);
        int b;
        case (r)
            3'd0: b = 10;  3'd1: b = 12;  3'd2: b = 36;  3'd3: b = 60;
            3'd4: b = 72;  3'd5: b = 72;  3'd6: b = 90;  default: b = 126;
        endcase
        return b << d;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            if (sparse) idle($urandom % 3);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic write_cfg(input logic [1:0] m, input logic [2:0] r, input logic [1:0] d);
        mode = m; rate = r; cdiv = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic read_pulse();
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int p;
        int w0;
        logic [DW-1:0] v;
        void'($urandom(32'd4242));
        mod_data = 24'h123456;
        idle(3);
        // R1 reset state
        check("R1 rdy_n", rdy_n, 1);
        check("R1 err", err_flag, 0);
        check("R1 data", data_out, 0);
        check("R1 active", active, 1);
        rst_n = 1'b1;
        idle(1);

        // R3 first result after two periods (default rate 100 -> 72)
        p = exp_period(3'b100, 2'b00);
        run_ticks(2*p - 1);
        check("R3 before first", rdy_n, 1);
        run_ticks(1);
        check("R3 rdy low", rdy_n, 0);
        check("R3 data", data_out, 24'h123456);
        check("R3 new_word", new_word, 1);

        // R5 early warning, R4 next period
        mod_data = 24'hABCDEF;
        run_ticks(p - WARN - 1);
        check("R5 before warn", rdy_n, 0);
        run_ticks(1);
        check("R5 warn high", rdy_n, 1);
        check("R3 data held", data_out, 24'h123456);
        run_ticks(WARN);
        check("R4 second result rdy", rdy_n, 0);
        check("R4 second result data", data_out, 24'hABCDEF);

        // R6 read strobe
        read_pulse();
        check("R6 rdy after read", rdy_n, 1);
        check("R6 data unchanged", data_out, 24'hABCDEF);

        // R2 divider, dense ticks: rate 000 div 8 -> 80
        write_cfg(2'b00, 3'b000, 2'b11);
        p = exp_period(3'b000, 2'b11);
        check("R2 period 80", p, 80);
        mod_data = 24'h0F0F0F;
        run_ticks(2*p - 1);
        check("R2 div8 early", rdy_n, 1);
        run_ticks(1);
        check("R2 div8 on time", rdy_n, 0);

        // R2 random codes with sparse ticks
        sparse = 1'b1;
        for (int k = 0; k < 8; k++) begin
            logic [2:0] r;
            logic [1:0] d;
            r = 3'($urandom % 8);
            d = 2'($urandom % 4);
            v = DW'($urandom);
            mod_data = v;
            write_cfg(2'b00, r, d);
            p = exp_period(r, d);
            run_ticks(2*p - 1);
            check("R2 random early", rdy_n, 1);
            run_ticks(1);
            check("R2 random rdy", rdy_n, 0);
            check("R2 random data", data_out, 32'(v));
        end
        sparse = 1'b0;

        // R7 restart by write mid-period; tick in same cycle ignored
        write_cfg(2'b00, 3'b000, 2'b00);
        p = 10;
        run_ticks(15);
        mode = 2'b00; cfg_wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; tick = 1'b0;
        check("R7 rdy after write", rdy_n, 1);
        mod_data = 24'h777777;
        run_ticks(2*p - 1);
        check("R7 restarted early", rdy_n, 1);
        run_ticks(1);
        check("R7 restarted result", data_out, 24'h777777);

        // R8 channel change restart
        run_ticks(3);
        chan = 2'b11;
        @(negedge clk);
        check("R8 rdy after chan", rdy_n, 1);
        mod_data = 24'h888888;
        run_ticks(2*p - 1);
        check("R8 early", data_out, 24'h777777);
        run_ticks(1);
        check("R8 result", data_out, 24'h888888);

        // R9 single mode
        mod_data = 24'h999999;
        write_cfg(2'b10, 3'b000, 2'b00);
        run_ticks(2*p - 1);
        check("R9 active during", active, 1);
        run_ticks(1);
        check("R9 rdy low", rdy_n, 0);
        check("R9 data", data_out, 24'h999999);
        idle(1);
        check("R9 powered down", active, 0);
        w0 = n_words;
        mod_data = 24'h111111;
        run_ticks(60);
        check("R9 rdy held", rdy_n, 0);
        check("R9 data held", data_out, 24'h999999);
        check("R9 no new words", n_words, w0);
        read_pulse();
        check("R9 rdy after read", rdy_n, 1);

        // R11 error flag set by clamped result
        mod_clamp = 1'b1; mod_data = 24'hFFFFFF;
        write_cfg(2'b00, 3'b000, 2'b00);
        run_ticks(2*p);
        check("R11 err set", err_flag, 1);

        // R10 power-down and reserved modes
        write_cfg(2'b11, 3'b000, 2'b00);
        check("R10 pd rdy", rdy_n, 1);
        check("R10 pd active", active, 0);
        check("R11 err kept by pd write", err_flag, 1);
        w0 = n_words;
        run_ticks(100);
        check("R10 pd no words", n_words, w0);
        write_cfg(2'b01, 3'b000, 2'b00);
        run_ticks(40);
        check("R10 reserved active", active, 0);
        check("R10 reserved no words", n_words, w0);

        // R11 cleared by starting write, reloaded per result
        write_cfg(2'b00, 3'b000, 2'b00);
        check("R11 err cleared", err_flag, 0);
        mod_clamp = 1'b0;
        run_ticks(2*p);
        check("R11 err from clean result", err_flag, 0);

        // R12 continuous-read reload
        cread = 1'b1;
        run_ticks(p);
        check("R12 reload pulse", reload_sr, 1);
        idle(1);
        check("R12 reload one cycle", reload_sr, 0);
        cread = 1'b0;
        run_ticks(p);
        check("R12 no reload", reload_sr, 0);
        check("R4 word without cread", new_word, 1);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule